// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Break Detection

This block is the receive half of an asynchronous serial port. It watches a single serial input line and turns each incoming character into a parallel byte. A receive clock, delivered as a one-cycle enable pulse on the system clock, runs at 1, 16 or 64 times the bit rate. In the two oversampled modes, a falling edge on the line is only accepted as a start bit if the line is still low half a bit later. This rejects short glitches and moves every later sample to the centre of its bit.

Each finished character goes into a one-entry holding buffer and raises a ready flag, which a read pulse clears. Parity, framing and overrun problems set sticky flags that only an explicit clear pulse removes. A separate break output rises when a whole character, including its stop position, arrives as a continuous low level, and falls again once the line returns high. The character length, parity setting and oversampling factor are static configuration inputs driven by the surrounding control logic.

Top module: `osrx_receiver`

## Requirements
- R1: With `baud_sel` = 10 (x16) or 11 (x64), a character is accepted and `rx_data` holds its bits, first received bit in bit 0. Each data bit is sampled one full bit period after the previous sample, and the first sample is half a bit after the start edge.
- R2: In x16 mode a low pulse lasting 8 receive ticks or fewer is ignored, and a low of 9 ticks or more starts a character. In x64 mode the limits are 32 ticks and 33 ticks.
- R3: With `baud_sel` = 00 or 01 (x1), every bit is sampled on one receive tick with no half-bit start check, and characters are received correctly.
- R4: `char_len` 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. The unused upper bits of `rx_data` read as zero.
- R5: `rx_ready` rises after a character completes, and a `data_rd` pulse clears it.
- R6: If a character completes while `rx_ready` is still set and no read occurs in that cycle, `err_overrun` is set and `rx_data` holds the newer character.
- R7: With `par_en` = 1, a parity bit follows the data bits. `par_even` = 1 selects even parity and 0 selects odd parity, and a mismatch sets `err_parity`.
- R8: A stop bit sampled low sets `err_framing`.
- R9: `err_parity`, `err_framing` and `err_overrun` stay set until an `err_clr` pulse. Later good characters and data reads leave them unchanged.
- R10: `break_det` is low after reset. It rises when every sampled position of a character, including the stop position, is low, and falls once `rxd` is high.
- R11: While `rx_en` is low, no character is started or completed and `rx_ready` does not rise.
- R12: Reset clears `rx_ready`, all error flags and `break_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | One-cycle pulse per receive clock rising edge |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receiver enable |
| baud_sel | input | 2 | Oversampling factor: 00/01 x1, 10 x16, 11 x64 |
| char_len | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| data_rd | input | 1 | Read pulse that clears `rx_ready` |
| err_clr | input | 1 | Pulse that clears all error flags |
| rx_data | output | 8 | Last received character, zero-extended |
| rx_ready | output | 1 | Unread character present |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_framing | output | 1 | Sticky framing error |
| break_det | output | 1 | Break condition on the line |

## Verification
The hardest situations to reach are the edges of the start-bit window: a low exactly one tick too short to count, followed by one exactly long enough. A second hard case is a start bit that is accepted even though it is shorter than a full bit, where the later samples must still land inside their bits. The stimulus produces these by counting receive ticks directly while it shapes the line. It sends 8-tick and 32-tick glitches, then characters whose start bit lasts only 9 or 33 ticks. Randomized frames then mix factors, lengths, parity settings, corrupted parity bits and low stop bits, and every result is compared against a model of the frame computed in the bench.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

    localparam int OSRX_DATA_W = 8;
    localparam int OSRX_CNT_W  = 6;
    localparam int OSRX_IDX_W  = 4;

    typedef enum logic [1:0] {
        OVS_X1_ALT = 2'b00,
        OVS_X1     = 2'b01,
        OVS_X16    = 2'b10,
        OVS_X64    = 2'b11
    } ovs_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [OSRX_DATA_W-1:0] data;
        logic                   par_bad;
        logic                   frame_bad;
        logic                   all_low;
    } rx_char_t;

    function automatic logic [OSRX_CNT_W-1:0] full_count(ovs_e m);
        case (m)
            OVS_X16: full_count = OSRX_CNT_W'(15);
            OVS_X64: full_count = OSRX_CNT_W'(63);
            default: full_count = '0;
        endcase
    endfunction

    function automatic logic [OSRX_CNT_W-1:0] half_count(ovs_e m);
        case (m)
            OVS_X16: half_count = OSRX_CNT_W'(7);
            OVS_X64: half_count = OSRX_CNT_W'(31);
            default: half_count = '0;
        endcase
    endfunction

    function automatic logic oversampled(ovs_e m);
        oversampled = (m == OVS_X16) || (m == OVS_X64);
    endfunction

    function automatic logic [OSRX_IDX_W-1:0] last_index(logic [1:0] len);
        last_index = OSRX_IDX_W'(4) + OSRX_IDX_W'(len);
    endfunction

    function automatic logic parity_good(logic [OSRX_DATA_W-1:0] d, logic pbit, logic even);
        logic x;
        x = ^{d, pbit};
        parity_good = even ? (x == 1'b0) : (x == 1'b1);
    endfunction

endpackage

// File: rtl/osrx_bit_timer.sv
module osrx_bit_timer #(
    parameter int CNT_W = osrx_pkg::OSRX_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = tick && (cnt_q == '0);
endmodule

// File: rtl/osrx_frame_fsm.sv
module osrx_frame_fsm
    import osrx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  rxd,
    input  logic                  rx_en,
    input  ovs_e                  mode,
    input  logic [1:0]            char_len,
    input  logic                  par_en,
    input  logic                  par_even,
    input  logic                  expire,
    output logic                  load,
    output logic [OSRX_CNT_W-1:0] load_val,
    output logic                  done,
    output rx_char_t              chr
);
    rx_state_e              state_q;
    logic [OSRX_IDX_W-1:0]  idx_q;
    logic [OSRX_DATA_W-1:0] shf_q;
    logic                   par_q;
    logic                   low_q;
    logic                   line_q;
    logic                   done_q;
    rx_char_t               chr_q;
    logic                   start_cond;

    assign start_cond = rx_en && line_q && !rxd;

    always_comb begin
        load     = 1'b0;
        load_val = full_count(mode);
        if (tick && rx_en) begin
            if (state_q == RX_IDLE) begin
                if (start_cond) begin
                    load     = 1'b1;
                    load_val = oversampled(mode) ? half_count(mode) : full_count(mode);
                end
            end else if (expire) begin
                load = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            shf_q   <= '0;
            par_q   <= 1'b0;
            low_q   <= 1'b0;
            line_q  <= 1'b1;
            done_q  <= 1'b0;
            chr_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                line_q <= rxd;
            end
            if (!rx_en) begin
                state_q <= RX_IDLE;
            end else if (tick) begin
                case (state_q)
                    RX_IDLE: begin
                        if (start_cond) begin
                            shf_q   <= '0;
                            idx_q   <= '0;
                            par_q   <= 1'b0;
                            low_q   <= 1'b1;
                            state_q <= oversampled(mode) ? RX_START : RX_DATA;
                        end
                    end
                    RX_START: begin
                        if (expire) begin
                            state_q <= rxd ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        if (expire) begin
                            shf_q[idx_q[2:0]] <= rxd;
                            low_q <= low_q & ~rxd;
                            idx_q <= idx_q + 1'b1;
                            if (idx_q == last_index(char_len)) begin
                                state_q <= par_en ? RX_PAR : RX_STOP;
                            end
                        end
                    end
                    RX_PAR: begin
                        if (expire) begin
                            par_q   <= rxd;
                            low_q   <= low_q & ~rxd;
                            state_q <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        if (expire) begin
                            chr_q.data      <= shf_q;
                            chr_q.par_bad   <= par_en && !parity_good(shf_q, par_q, par_even);
                            chr_q.frame_bad <= ~rxd;
                            chr_q.all_low   <= low_q & ~rxd;
                            done_q          <= 1'b1;
                            state_q         <= RX_IDLE;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign done = done_q;
    assign chr  = chr_q;
endmodule

// File: rtl/osrx_status.sv
module osrx_status
    import osrx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   done,
    input  rx_char_t               chr,
    input  logic                   rxd,
    input  logic                   data_rd,
    input  logic                   err_clr,
    output logic [OSRX_DATA_W-1:0] rx_data,
    output logic                   rx_ready,
    output logic                   err_parity,
    output logic                   err_overrun,
    output logic                   err_framing,
    output logic                   break_det
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            err_framing <= 1'b0;
            break_det   <= 1'b0;
        end else begin
            if (done) begin
                rx_data  <= chr.data;
                rx_ready <= 1'b1;
            end else if (data_rd) begin
                rx_ready <= 1'b0;
            end

            if (done && rx_ready && !data_rd) begin
                err_overrun <= 1'b1;
            end else if (err_clr) begin
                err_overrun <= 1'b0;
            end

            if (done && chr.par_bad) begin
                err_parity <= 1'b1;
            end else if (err_clr) begin
                err_parity <= 1'b0;
            end

            if (done && chr.frame_bad) begin
                err_framing <= 1'b1;
            end else if (err_clr) begin
                err_framing <= 1'b0;
            end

            if (done && chr.all_low) begin
                break_det <= 1'b1;
            end else if (rxd) begin
                break_det <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver
    import osrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic [1:0] baud_sel,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       data_rd,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       err_framing,
    output logic       break_det
);
    logic                  load_w;
    logic [OSRX_CNT_W-1:0] load_val_w;
    logic                  expire_w;
    logic                  done_w;
    rx_char_t              chr_w;
    ovs_e                  mode_w;

    assign mode_w = ovs_e'(baud_sel);

    osrx_bit_timer #(.CNT_W(OSRX_CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (rx_tick),
        .load     (load_w),
        .load_val (load_val_w),
        .expire   (expire_w)
    );

    osrx_frame_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (rx_tick),
        .rxd      (rxd),
        .rx_en    (rx_en),
        .mode     (mode_w),
        .char_len (char_len),
        .par_en   (par_en),
        .par_even (par_even),
        .expire   (expire_w),
        .load     (load_w),
        .load_val (load_val_w),
        .done     (done_w),
        .chr      (chr_w)
    );

    osrx_status u_status (
        .clk         (clk),
        .rst         (rst),
        .done        (done_w),
        .chr         (chr_w),
        .rxd         (rxd),
        .data_rd     (data_rd),
        .err_clr     (err_clr),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_parity  (err_parity),
        .err_overrun (err_overrun),
        .err_framing (err_framing),
        .break_det   (break_det)
    );
endmodule

// File: rtl/osrx_checker.sv
module osrx_checker
    import osrx_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     rx_en,
    input logic     rxd,
    input logic     data_rd,
    input logic     err_clr,
    input logic     rx_ready,
    input logic     err_parity,
    input logic     err_overrun,
    input logic     err_framing,
    input logic     break_det,
    input logic     done_w,
    input rx_char_t chr_w
);
    a_r5_ready_sets: assert property (@(posedge clk) disable iff (rst)
        done_w |=> rx_ready);
    a_r5_ready_clears: assert property (@(posedge clk) disable iff (rst)
        data_rd && !done_w |=> !rx_ready);
    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        done_w && rx_ready && !data_rd |=> err_overrun);
    a_r8_framing_sets: assert property (@(posedge clk) disable iff (rst)
        done_w && chr_w.frame_bad |=> err_framing);
    a_r9_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        err_parity && !err_clr |=> err_parity);
    a_r9_framing_sticky: assert property (@(posedge clk) disable iff (rst)
        err_framing && !err_clr |=> err_framing);
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        err_overrun && !err_clr |=> err_overrun);
    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        err_clr && !done_w |=> !err_parity && !err_framing && !err_overrun);
    a_r10_break_release: assert property (@(posedge clk) disable iff (rst)
        rxd && !done_w |=> !break_det);
    a_r10_break_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(break_det) |-> $past(done_w && chr_w.all_low));
    a_r11_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !done_w);
endmodule

bind osrx_receiver osrx_checker u_chk (.*);

// File: tb/osrx_receiver_test.sv
module osrx_receiver_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] baud_sel = 2'b10;
    logic [1:0] char_len = 2'b11;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       data_rd = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_overrun, err_framing, break_det;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    osrx_receiver uut (
        .clk(clk), .rst(rst), .rx_tick(rx_tick), .rxd(rxd), .rx_en(rx_en),
        .baud_sel(baud_sel), .char_len(char_len), .par_en(par_en),
        .par_even(par_even), .data_rd(data_rd), .err_clr(err_clr),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
        .err_overrun(err_overrun), .err_framing(err_framing), .break_det(break_det)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rx_tick = 1'b1;
            @(negedge clk) rx_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int factor(input logic [1:0] s);
        if (s == 2'b10) return 16;
        if (s == 2'b11) return 64;
        return 1;
    endfunction

    function automatic logic [7:0] mask_data(input logic [7:0] d, input int nb);
        return d & 8'((1 << nb) - 1);
    endfunction

    function automatic bit good_par(input logic [7:0] d, input int nb, input bit even);
        bit x;
        x = ^mask_data(d, nb);
        return even ? x : ~x;
    endfunction

    task automatic send(input logic [7:0] d, input int start_len, input bit pbit, input bit stopv);
        int f;
        int nb;
        f  = factor(baud_sel);
        nb = 5 + int'(char_len);
        rxd = 1'b0;
        tick(start_len);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            tick(f);
        end
        if (par_en) begin
            rxd = pbit;
            tick(f);
        end
        rxd = stopv;
        tick(f);
        if (stopv) tick(2);
    endtask

    task automatic send_ok(input logic [7:0] d);
        send(d, factor(baud_sel), good_par(d, 5 + int'(char_len), par_even), 1'b1);
    endtask

    task automatic rd_pulse();
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr_pulse();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        repeat (5) @(negedge clk);
        chk("R12 ready", rx_ready, 0);
        chk("R12 errors", {err_parity, err_overrun, err_framing}, 0);
        chk("R12 R10 break", break_det, 0);
        rst = 1'b0;
        rx_en = 1'b1;
        tick(2);

        // R1 x16 and x64 centre sampling
        baud_sel = 2'b10; char_len = 2'b11; par_en = 0;
        send_ok(8'hA5);
        chk("R1 x16 data", rx_data, 8'hA5);
        chk("R5 ready set", rx_ready, 1);
        chk("R1 no errors", {err_parity, err_overrun, err_framing}, 0);
        rd_pulse();
        chk("R5 ready cleared", rx_ready, 0);
        baud_sel = 2'b11;
        send_ok(8'h3C);
        chk("R1 x64 data", rx_data, 8'h3C);
        rd_pulse();

        // R3 x1 with even parity
        baud_sel = 2'b01; par_en = 1; par_even = 1;
        send_ok(8'h96);
        chk("R3 x1 data", rx_data, 8'h96);
        chk("R3 R7 parity ok", err_parity, 0);
        rd_pulse();
        baud_sel = 2'b00; par_en = 0;
        send_ok(8'h4B);
        chk("R3 x1 alt data", rx_data, 8'h4B);
        rd_pulse();

        // R4 lengths
        baud_sel = 2'b10;
        for (int l = 0; l < 3; l++) begin
            char_len = 2'(l);
            send_ok(8'hFF);
            chk("R4 zero extend", rx_data, mask_data(8'hFF, 5 + l));
            rd_pulse();
        end
        char_len = 2'b11;

        // R2 glitch window
        rxd = 1'b0; tick(8); rxd = 1'b1; tick(40);
        chk("R2 x16 8-tick glitch", rx_ready, 0);
        send(8'h5A, 9, 1'b0, 1'b1);
        chk("R2 x16 9-tick start ready", rx_ready, 1);
        chk("R2 x16 9-tick start data", rx_data, 8'h5A);
        rd_pulse();
        baud_sel = 2'b11;
        rxd = 1'b0; tick(32); rxd = 1'b1; tick(140);
        chk("R2 x64 32-tick glitch", rx_ready, 0);
        send(8'hC3, 33, 1'b0, 1'b1);
        chk("R2 x64 33-tick start data", rx_data, 8'hC3);
        rd_pulse();
        baud_sel = 2'b10;

        // R6 overrun, R9 sticky
        send_ok(8'h11);
        send_ok(8'h22);
        chk("R6 overrun", err_overrun, 1);
        chk("R6 newer data", rx_data, 8'h22);
        rd_pulse();
        send_ok(8'h33);
        chk("R9 overrun sticky", err_overrun, 1);
        rd_pulse();
        clr_pulse();
        chk("R9 overrun cleared", err_overrun, 0);

        // R7 parity error, odd parity
        par_en = 1; par_even = 0;
        send(8'h0F, 16, ~good_par(8'h0F, 8, 1'b0), 1'b1);
        chk("R7 parity mismatch", err_parity, 1);
        rd_pulse();
        send_ok(8'h0E);
        chk("R9 parity sticky", err_parity, 1);
        rd_pulse();
        clr_pulse();
        chk("R9 parity cleared", err_parity, 0);
        par_en = 0;

        // R8 framing
        send(8'h55, 16, 1'b0, 1'b0);
        chk("R8 framing", err_framing, 1);
        chk("R10 no break on data", break_det, 0);
        rxd = 1'b1; tick(2);
        rd_pulse(); clr_pulse();
        chk("R9 framing cleared", err_framing, 0);

        // R10 break
        send(8'h00, 16, 1'b0, 1'b0);
        chk("R10 break set", break_det, 1);
        rxd = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 break released", break_det, 0);
        tick(2);
        rd_pulse(); clr_pulse();

        // R11 disabled
        rx_en = 1'b0;
        send_ok(8'h77);
        chk("R11 disabled no char", rx_ready, 0);
        rx_en = 1'b1;
        tick(2);

        // randomized frames
        for (int it = 0; it < 30; it++) begin
            int r;
            logic [7:0] d;
            bit badpar, stopv, pb;
            int nb;
            r = int'($urandom % 8);
            baud_sel = (r < 3) ? 2'b01 : ((r < 7) ? 2'b10 : 2'b11);
            char_len = 2'($urandom % 4);
            par_en   = 1'($urandom % 2);
            par_even = 1'($urandom % 2);
            d        = 8'($urandom);
            badpar   = ($urandom % 4) == 0;
            stopv    = ($urandom % 6) != 0;
            nb       = 5 + int'(char_len);
            pb       = good_par(d, nb, par_even) ^ badpar;
            send(d, factor(baud_sel), pb, stopv);
            chk("R1 R4 random data", rx_data, mask_data(d, nb));
            chk("R5 random ready", rx_ready, 1);
            chk("R7 random parity", err_parity, par_en && badpar);
            chk("R8 random framing", err_framing, !stopv);
            chk("R6 random no overrun", err_overrun, 0);
            rxd = 1'b1; tick(2);
            rd_pulse(); clr_pulse();
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule